// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the command register that software uses to send an inter-processor interrupt. The register is 64 bits wide and is reached through a 32-bit write port and a 32-bit read port, with one select bit choosing the half. The upper half only holds the destination. It is stored and has no other effect, so software writes it first. A write to the lower half is the trigger. It loads the vector, delivery mode, destination mode, level, trigger mode and destination shorthand, and launches one message on a valid/ready output port.

A read-only status bit in the lower half stays at 1 while a launched message waits for the receiver. The message is captured at launch and does not change while it waits. A static input chooses between two destination layouts. In the narrow layout, 8 destination bits sit at the top of the upper half. In the wide layout, the whole upper half is the destination. When a shorthand code is chosen, the outgoing destination is forced to zero. A sticky error flag records trigger writes that were refused, either because a send was still pending or because the delivery mode was reserved.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, both halves read as zero, the status bit reads 0, `msg_valid` is 0 and `err_flag` is 0.
- R2: A write to the low half (`wr_hi`=0) stores the vector (bits 7:0), delivery mode (10:8), destination mode (11), level (14), trigger mode (15) and shorthand (19:18). Bits 13, 17:16 and 31:20 read back as zero. Bit 12 reads the send status and ignores written data.
- R3: A write to the high half (`wr_hi`=1) launches nothing. With `wide_dest`=0 the high half reads back only bits 31:24 and the rest as zero. With `wide_dest`=1 it reads back all 32 bits.
- R4: An accepted low-half write with a non-reserved delivery mode raises `msg_valid` and the status bit after that clock edge. The message carries the written low-half fields.
- R5: With shorthand 00, `msg_dest` is high-half bits 31:24 zero-extended when `wide_dest`=0, and the whole high half when `wide_dest`=1.
- R6: With shorthand 01 (self), 10 (all including sender) or 11 (all excluding sender), `msg_dest` is zero.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` stays 1 and every message output stays stable. After a cycle with both at 1, `msg_valid` and the status bit are 0.
- R8: A low-half write while the status is 1 leaves the stored fields and the message unchanged and sets `err_flag`.
- R9: A low-half write with delivery mode 011 or 111 while idle stores the fields, launches nothing and sets `err_flag`.
- R10: `err_flag` never falls once set until the next reset.
- R11: A high-half write while a message is pending does not change the pending message's destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_dest | input | 1 | Static layout choice: 0 = 8-bit destination, 1 = 32-bit destination |
| wr_en | input | 1 | Write strobe for one half |
| wr_hi | input | 1 | Write half select: 1 = upper half, 0 = lower half (trigger) |
| wr_data | input | 32 | Write data |
| rd_hi | input | 1 | Read half select |
| rd_data | output | 32 | Read data of the selected half |
| err_flag | output | 1 | Sticky record of refused trigger writes |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_level | output | 1 | Level bit |
| msg_trigger | output | 1 | Trigger mode, 1 = level |
| msg_shorthand | output | 2 | Destination shorthand code |
| msg_dest | output | 32 | Destination, zero when a shorthand is used |

## Verification
The hardest case to reach from the ports is a pending message whose stored register state is being disturbed. This means a second trigger write, or a write that restages the destination, landing while the receiver still holds `msg_ready` low, including the edge where acceptance and a new trigger coincide. The bench holds `msg_ready` low on purpose and issues those writes in that window. It then runs a long stream in which `msg_ready` and the writes are random and unrelated. A behavioural model checks the read data, the flag and the held message on every cycle.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;

  localparam int REG_W    = 32;
  localparam int VEC_W    = 8;
  localparam int MODE_W   = 3;
  localparam int SH_W     = 2;
  localparam int NARROW_W = 8;

  // Bit positions inside the low half
  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int LOG_BIT  = 11;
  localparam int STAT_BIT = 12;
  localparam int LVL_BIT  = 14;
  localparam int TRIG_BIT = 15;
  localparam int SH_LSB   = 18;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV_A  = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSV_B  = 3'b111
  } dmode_e;

  typedef enum logic [SH_W-1:0] {
    SH_NONE   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } short_e;

  typedef struct packed {
    short_e             sh;
    logic               trig;
    logic               lvl;
    logic               logical;
    dmode_e             mode;
    logic [VEC_W-1:0]   vec;
  } cmd_lo_t;

  typedef struct packed {
    cmd_lo_t            f;
    logic [REG_W-1:0]   dest;
  } ipi_msg_t;

  function automatic logic mode_reserved(dmode_e m);
    return (m == DM_RSV_A) || (m == DM_RSV_B);
  endfunction

  function automatic cmd_lo_t decode_lo(logic [REG_W-1:0] w);
    cmd_lo_t r;
    r.vec     = w[VEC_LSB +: VEC_W];
    r.mode    = dmode_e'(w[MODE_LSB +: MODE_W]);
    r.logical = w[LOG_BIT];
    r.lvl     = w[LVL_BIT];
    r.trig    = w[TRIG_BIT];
    r.sh      = short_e'(w[SH_LSB +: SH_W]);
    return r;
  endfunction

endpackage

// File: rtl/ipi_cmd_fields.sv
module ipi_cmd_fields
  import ipi_cmd_pkg::*;
#(
  parameter int DW  = REG_W,
  parameter int NDW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_we,
  input  logic          hi_we,
  input  cmd_lo_t       lo_d,
  input  logic [DW-1:0] hi_d,
  input  logic          wide_dest,
  input  logic          rd_hi,
  input  logic          pending,
  output cmd_lo_t       lo_q,
  output logic [DW-1:0] hi_q,
  output logic [DW-1:0] rd_data
);

  localparam logic [DW-1:0] NARROW_MASK = {{NDW{1'b1}}, {(DW-NDW){1'b0}}};

  cmd_lo_t       lo_n;
  logic [DW-1:0] hi_n;
  logic [DW-1:0] lo_view;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (lo_we) lo_n = lo_d;
    if (hi_we) hi_n = hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  always_comb begin
    lo_view                      = '0;
    lo_view[VEC_LSB +: VEC_W]    = lo_q.vec;
    lo_view[MODE_LSB +: MODE_W]  = lo_q.mode;
    lo_view[LOG_BIT]             = lo_q.logical;
    lo_view[STAT_BIT]            = pending;
    lo_view[LVL_BIT]             = lo_q.lvl;
    lo_view[TRIG_BIT]            = lo_q.trig;
    lo_view[SH_LSB +: SH_W]      = lo_q.sh;
  end

  always_comb begin
    if (rd_hi) rd_data = wide_dest ? hi_q : (hi_q & NARROW_MASK);
    else       rd_data = lo_view;
  end

  // Stored low fields only move on an accepted trigger write (R8)
  assert_lo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_we |=> $stable(lo_q));

endmodule

// File: rtl/ipi_launch_ctrl.sv
module ipi_launch_ctrl
  import ipi_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_lo,
  input  dmode_e req_mode,
  input  logic   msg_ready,
  output logic   lo_we,
  output logic   launch,
  output logic   pending_q,
  output logic   err_q
);

  logic accept;
  logic refuse;
  logic pend_n;
  logic err_n;

  always_comb begin
    accept = pending_q && msg_ready;
    lo_we  = wr_lo && !pending_q;
    launch = lo_we && !mode_reserved(req_mode);
    refuse = wr_lo && (pending_q || mode_reserved(req_mode));
    pend_n = pending_q;
    if (accept) pend_n = 1'b0;
    if (launch) pend_n = 1'b1;
    err_n  = err_q | refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      pending_q <= pend_n;
      err_q     <= err_n;
    end
  end

  assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !msg_ready) |=> pending_q);

  assert_clear_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && msg_ready) |=> !pending_q);

  assert_busy_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && pending_q) |=> err_q);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_q));

endmodule

// File: rtl/ipi_msg_snap.sv
module ipi_msg_snap
  import ipi_cmd_pkg::*;
#(
  parameter int DW  = REG_W,
  parameter int NDW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  cmd_lo_t       lo_d,
  input  logic [DW-1:0] hi_q,
  input  logic          wide_dest,
  input  logic          valid,
  input  logic          ready,
  output ipi_msg_t      msg_q
);

  logic [DW-1:0] dest_fmt;
  ipi_msg_t      msg_n;

  generate
    if (NDW < DW) begin : g_narrow_pad
      always_comb begin
        dest_fmt = wide_dest ? hi_q : {{(DW-NDW){1'b0}}, hi_q[DW-1 -: NDW]};
        if (lo_d.sh != SH_NONE) dest_fmt = '0;
      end
    end else begin : g_full
      always_comb begin
        dest_fmt = hi_q;
        if (lo_d.sh != SH_NONE) dest_fmt = '0;
      end
    end
  endgenerate

  always_comb begin
    msg_n = msg_q;
    if (launch) begin
      msg_n.f    = lo_d;
      msg_n.dest = dest_fmt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_q <= '0;
    else        msg_q <= msg_n;
  end

  assert_msg_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> $stable(msg_q));

  assert_short_dest_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && lo_d.sh != SH_NONE) |=> (msg_q.dest == '0));

endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_cmd_pkg::*;
#(
  parameter int DW  = REG_W,
  parameter int NDW = NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_dest,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_hi,
  output logic [DW-1:0]     rd_data,
  output logic              err_flag,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [MODE_W-1:0] msg_mode,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [SH_W-1:0]   msg_shorthand,
  output logic [DW-1:0]     msg_dest
);

  logic     rs_meta;
  logic     rst_i;
  logic     wr_lo;
  logic     wr_up;
  cmd_lo_t  lo_d;
  cmd_lo_t  lo_q;
  logic [DW-1:0] hi_q;
  logic     lo_we;
  logic     launch;
  logic     pending;
  ipi_msg_t msg_q;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_i   <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_i   <= rs_meta;
    end
  end

  always_comb begin
    wr_lo = wr_en && !wr_hi;
    wr_up = wr_en && wr_hi;
    lo_d  = decode_lo(wr_data);
  end

  ipi_launch_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i),
    .wr_lo     (wr_lo),
    .req_mode  (lo_d.mode),
    .msg_ready (msg_ready),
    .lo_we     (lo_we),
    .launch    (launch),
    .pending_q (pending),
    .err_q     (err_flag)
  );

  ipi_cmd_fields #(.DW(DW), .NDW(NDW)) u_fields (
    .clk       (clk),
    .rst_n     (rst_i),
    .lo_we     (lo_we),
    .hi_we     (wr_up),
    .lo_d      (lo_d),
    .hi_d      (wr_data),
    .wide_dest (wide_dest),
    .rd_hi     (rd_hi),
    .pending   (pending),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .rd_data   (rd_data)
  );

  ipi_msg_snap #(.DW(DW), .NDW(NDW)) u_snap (
    .clk       (clk),
    .rst_n     (rst_i),
    .launch    (launch),
    .lo_d      (lo_d),
    .hi_q      (hi_q),
    .wide_dest (wide_dest),
    .valid     (pending),
    .ready     (msg_ready),
    .msg_q     (msg_q)
  );

  always_comb begin
    msg_valid     = pending;
    msg_vector    = msg_q.f.vec;
    msg_mode      = msg_q.f.mode;
    msg_logical   = msg_q.f.logical;
    msg_level     = msg_q.f.lvl;
    msg_trigger   = msg_q.f.trig;
    msg_shorthand = msg_q.f.sh;
    msg_dest      = msg_q.dest;
  end

  assert_reserved_no_send_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_lo && !msg_valid && mode_reserved(lo_d.mode)) |=> !msg_valid);

  assert_upper_write_no_send_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_up && !msg_valid) |=> !msg_valid);

  assert_launch_raises_R4: assert property (@(posedge clk) disable iff (!rst_i)
    launch |=> (msg_valid && msg_vector == $past(wr_data[VEC_LSB +: VEC_W])));

  assert_lo_store_R2: assert property (@(posedge clk) disable iff (!rst_i)
    lo_we |=> (lo_q.vec == $past(wr_data[VEC_LSB +: VEC_W])));

endmodule

// File: tb/ipi_cmd_reg_test.sv
module ipi_cmd_reg_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_dest;
  logic        wr_en;
  logic        wr_hi;
  logic [31:0] wr_data;
  logic        rd_hi;
  logic [31:0] rd_data;
  logic        err_flag;
  logic        msg_valid;
  logic        msg_ready;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic        msg_logical;
  logic        msg_level;
  logic        msg_trigger;
  logic [1:0]  msg_shorthand;
  logic [31:0] msg_dest;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ipi_cmd_reg uut (
    .clk(clk), .rst_n(rst_n), .wide_dest(wide_dest), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_hi(rd_hi), .rd_data(rd_data), .err_flag(err_flag),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand), .msg_dest(msg_dest)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  int          rcnt = 0;
  logic [31:0] m_lo, m_hi;
  bit          m_pend, m_err;
  logic [7:0]  e_vec;
  logic [2:0]  e_mode;
  logic        e_log, e_lvl, e_trig;
  logic [1:0]  e_sh;
  logic [31:0] e_dest;

  always @(posedge clk) begin
    bit old;
    if (!rst_n) begin
      rcnt = 0; m_lo = 0; m_hi = 0; m_pend = 0; m_err = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      old = m_pend;
      if (old && msg_ready) m_pend = 0;
      if (wr_en && wr_hi) m_hi = wr_data;
      if (wr_en && !wr_hi) begin
        if (old) m_err = 1;
        else begin
          m_lo = wr_data & 32'h000CCFFF;
          if (wr_data[9:8] == 2'b11) m_err = 1;
          else begin
            m_pend = 1;
            e_vec  = wr_data[7:0];
            e_mode = wr_data[10:8];
            e_log  = wr_data[11];
            e_lvl  = wr_data[14];
            e_trig = wr_data[15];
            e_sh   = wr_data[19:18];
            if (wr_data[19:18] != 0) e_dest = 0;
            else e_dest = wide_dest ? m_hi : {24'h0, m_hi[31:24]};
          end
        end
      end
    end
    #3;
    if (rst_n && rcnt >= 2) begin
      check("R7 valid", {63'd0, msg_valid}, {63'd0, m_pend});
      check("R10 err", {63'd0, err_flag}, {63'd0, m_err});
      if (rd_hi) check("R3 rd_hi", {32'd0, rd_data},
                       {32'd0, wide_dest ? m_hi : (m_hi & 32'hFF000000)});
      else       check("R2 rd_lo", {32'd0, rd_data}, {32'd0, m_lo | (32'(m_pend) << 12)});
      if (m_pend) begin
        check("R4 fields", {48'd0, msg_vector, msg_mode, msg_logical, msg_level, msg_trigger, msg_shorthand},
                           {48'd0, e_vec, e_mode, e_log, e_lvl, e_trig, e_sh});
        check("R5 dest", {32'd0, msg_dest}, {32'd0, e_dest});
      end
    end
  end

  task automatic wr(bit hi, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset(bit wide);
    @(negedge clk);
    rst_n = 0; wide_dest = wide; msg_ready = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wide_dest = 0; wr_en = 0; wr_hi = 0; wr_data = 0; rd_hi = 0; msg_ready = 0;
    do_reset(0);
    // R1 reset state
    rd_hi = 0; #1 check("R1 lo", {32'd0, rd_data}, 0);
    rd_hi = 1; #1 check("R1 hi", {32'd0, rd_data}, 0);
    check("R1 valid/err", {62'd0, msg_valid, err_flag}, 0);

    // R3 upper half only stored, narrow view
    wr(1, 32'hA5C3_3C11);
    check("R3 narrow readback", {32'd0, rd_data}, 64'hA500_0000);
    check("R3 no launch", {63'd0, msg_valid}, 0);

    // R2/R4/R5 launch with junk in reserved bits
    rd_hi = 0;
    wr(0, 32'h8003_FD41);
    check("R2 readback", {32'd0, rd_data}, 64'h0000_DD41);
    check("R4 valid", {63'd0, msg_valid}, 1);
    check("R5 narrow dest", {32'd0, msg_dest}, 64'hA5);
    // R8 busy trigger ignored
    wr(0, 32'h0000_0022);
    check("R8 fields kept", {32'd0, rd_data}, 64'h0000_DD41);
    check("R8 err set", {63'd0, err_flag}, 1);
    check("R8 message kept", {56'd0, msg_vector}, 64'h41);
    // R11 restaging upper half while pending
    wr(1, 32'h7700_0000);
    check("R11 dest kept", {32'd0, msg_dest}, 64'hA5);
    repeat (3) @(negedge clk);
    check("R7 held", {63'd0, msg_valid}, 1);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
    check("R7 cleared", {63'd0, msg_valid}, 0);
    // R9 reserved mode
    wr(0, 32'h0000_0310);
    check("R9 no send", {63'd0, msg_valid}, 0);
    check("R9 stored", {32'd0, rd_data}, 64'h0000_0310);
    repeat (5) @(negedge clk);
    check("R10 still set", {63'd0, err_flag}, 1);

    // Wide layout
    do_reset(1);
    check("R10 cleared by reset", {63'd0, err_flag}, 0);
    rd_hi = 1;
    wr(1, 32'h1234_5678);
    check("R3 wide readback", {32'd0, rd_data}, 64'h1234_5678);
    msg_ready = 1;
    wr(0, 32'h0000_0020);
    check("R5 wide dest", {32'd0, msg_dest}, 64'h1234_5678);
    @(negedge clk);
    check("R7 accepted", {63'd0, msg_valid}, 0);
    msg_ready = 0;
    wr(0, 32'h0008_0030);
    check("R6 shorthand dest", {32'd0, msg_dest}, 0);
    check("R6 shorthand code", {62'd0, msg_shorthand}, 2);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;

    // Random stream, checked each cycle by the model
    for (int ph = 0; ph < 2; ph++) begin
      do_reset(ph[0]);
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        wr_en     = ($urandom % 3) == 0;
        wr_hi     = ($urandom % 3) == 0;
        wr_data   = $urandom;
        rd_hi     = $urandom % 2;
        msg_ready = ($urandom % 4) == 0;
      end
      @(negedge clk);
      wr_en = 0;
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule